// File: doc/BRIEF.md
# Asynchronous Parallel Flash Bus Front-End

This block is the device-side bus front-end of a NOR-style parallel flash, run from a fast internal clock. The external strobes are chip select `cs_n`, write strobe `wr_n`, read-drive strobe `rd_n` and hardware reset `hw_rst_n`, all active low. With the address and write-data buses, these strobes pass through two-flop synchronisers. A bus write is the window in which chip select and write strobe are both low while the read-drive strobe is high. The command or data word is taken at the end of that window, on whichever of chip select or write strobe goes high first. Reads drive `rdata` and raise `rdata_en`. When `rdata_en` is low, the pad should be treated as high impedance.

A state machine controls the access modes. Its states are `ST_WAKE`, `ST_IDLE`, `ST_PROG_ARM`, `ST_ERASE_ARM`, `ST_PROG_RUN` and `ST_ERASE_RUN`. A read view register selects whether reads return array data (`RD_ARRAY`) or the status word (`RD_STATUS`).

The transitions are as follows:
- Reset forces `ST_WAKE`. After a wake-up count, `ST_WAKE` moves to `ST_IDLE`.
- In `ST_IDLE`, command 0x40 moves to `ST_PROG_ARM` and command 0x20 moves to `ST_ERASE_ARM`. Commands 0xFF and 0x70 change the view only.
- From `ST_PROG_ARM`, the next write moves to `ST_PROG_RUN`.
- From `ST_ERASE_ARM`, a write of 0xD0 moves to `ST_ERASE_RUN`. Any other write falls back to `ST_IDLE`.
- Each run state returns to `ST_IDLE` when its cycle counter expires.

The storage is a small word array with a validity flag per word. A hardware reset during a run state clears the flags of the word or block being worked on.

Top module: `pflash_bus_frontend`

## Requirements
- R1: While `hw_rst_n` is low, `rdata_en` is 0 at once. After reset the view is read-array. After a 0x70 command, a read returns the status word 16'h0080 (bit 7 = ready).
- R2: For WAKE_CYC cycles after the synchronised release of `hw_rst_n`, `rdata_en` stays 0 and bus writes are ignored.
- R3: A bus write counts only when `cs_n` and `wr_n` are both low with `rd_n` high. Address and data are taken from that window when the first of `cs_n` or `wr_n` rises. A window with `rd_n` low has no effect.
- R4: With `rd_n` high, `rdata_en` is 0.
- R5: With `cs_n` high, `rdata_en` is 0 whatever `rd_n` does.
- R6: Commands use the low data byte. 0xFF selects the array view and 0x70 selects the status view. Codes other than 0xFF, 0x70, 0x40 and 0x20 leave the view and state unchanged.
- R7: A 0x40 command followed by a write of address A and data D keeps the block busy for PROG_CYC cycles. After that, word A reads as D.
- R8: A 0x20 command followed by 0xD0 at address A sets every word of A's block (addresses sharing bits [ADDR_W-1:BLK_W]) to 16'hFFFF after ERASE_CYC cycles. A 0x20 command followed by any other code cancels the erase and returns to the array view.
- R9: While busy, reads return 16'h0000 (ready bit 0) in either view, and writes are ignored. Raising `cs_n` does not stop the operation.
- R10: A reset during a program makes the target word read as POISON (16'hDEAD). A reset during an erase does the same to the whole target block. Other words keep their contents.
- R11: `rdata_en` and `rdata` follow the pins through two synchroniser stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| hw_rst_n | input | 1 | Hardware reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read-drive strobe, active low |
| bus_addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data / command |
| rdata | output | DATA_W | Read data |
| rdata_en | output | 1 | Read data drive enable; 0 means high impedance |

## Verification
The bench first checks the chip-select-first and write-strobe-first endings of a write. A design that latched on the later edge, or on the wrong one, would store a different word. It sends commands during the wake window and then expects array data. A design that opened the bus too early would show status data or enable the outputs. It reads while a program or erase is running, with chip select raised, to find designs that expose array data or drop the operation. Finally, it resets during each kind of run and expects the poison word only at the targets. A design that forgot the abort, or invalidated too wide a range, would fail there.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    typedef enum logic [2:0] {
        ST_WAKE,
        ST_IDLE,
        ST_PROG_ARM,
        ST_ERASE_ARM,
        ST_PROG_RUN,
        ST_ERASE_RUN
    } fbf_state_e;

    typedef enum logic {
        RD_ARRAY,
        RD_STATUS
    } fbf_view_e;

    localparam logic [7:0] CMD_VIEW_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_VIEW_STATUS = 8'h70;
    localparam logic [7:0] CMD_PROG        = 8'h40;
    localparam logic [7:0] CMD_ERASE       = 8'h20;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] STAT_READY      = 8'h80;

endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) stg <= d;
        end else begin : g_chain
            always_ff @(posedge clk) stg <= {stg[STAGES-2:0], d};
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/fbf_wr_capture.sv
module fbf_wr_capture #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_s,
    input  logic          cs_s,
    input  logic          wr_s,
    input  logic          rd_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          wr_stb,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_data
);
    logic active, active_q;

    assign active = !cs_s && !wr_s && rd_s;

    always_ff @(posedge clk) begin
        if (!rst_s) active_q <= 1'b0;
        else        active_q <= active;
    end

    always_ff @(posedge clk) begin
        if (active) begin
            lat_addr <= addr_s;
            lat_data <= data_s;
        end
    end

    // first of cs/wr going high closes the window
    assign wr_stb = active_q && (cs_s || wr_s);

    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_s)
        wr_stb |=> !wr_stb);

    p_stb_needs_close_r3: assert property (@(posedge clk) disable iff (!rst_s)
        (wr_stb && $past(rst_s)) |-> ($past(!cs_s && !wr_s && rd_s)));
endmodule

// File: rtl/fbf_store.sv
module fbf_store #(
    parameter int          AW     = 4,
    parameter int          DW     = 16,
    parameter int          BLK_W  = 2,
    parameter logic [15:0] POISON = 16'hDEAD
) (
    input  logic          clk,
    input  logic          rst_s,
    input  logic          do_prog,
    input  logic          do_erase,
    input  logic          abort_prog,
    input  logic          abort_erase,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];
    logic [WORDS-1:0] ok;

    always_ff @(posedge clk) begin
        for (int w = 0; w < WORDS; w++) begin
            if (do_prog && op_addr == AW'(w)) begin
                mem[w] <= op_data;
                ok[w]  <= 1'b1;
            end else if (do_erase && (op_addr >> BLK_W) == (AW'(w) >> BLK_W)) begin
                mem[w] <= '1;
                ok[w]  <= 1'b1;
            end else if (abort_prog && op_addr == AW'(w)) begin
                ok[w]  <= 1'b0;
            end else if (abort_erase && (op_addr >> BLK_W) == (AW'(w) >> BLK_W)) begin
                ok[w]  <= 1'b0;
            end
        end
    end

    assign rd_word = ok[rd_addr] ? mem[rd_addr] : DW'(POISON);

    p_prog_lands_r7: assert property (@(posedge clk) disable iff (!rst_s)
        do_prog |=> (ok[$past(op_addr)] && mem[$past(op_addr)] == $past(op_data)));

    p_abort_marks_r10: assert property (@(posedge clk)
        abort_prog |=> !ok[$past(op_addr)]);
endmodule

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
    import fbf_pkg::*;
#(
    parameter int AW        = 4,
    parameter int DW        = 16,
    parameter int WAKE_CYC  = 12,
    parameter int PROG_CYC  = 16,
    parameter int ERASE_CYC = 40
) (
    input  logic          clk,
    input  logic          rst_s,
    input  logic          wr_stb,
    input  logic [AW-1:0] lat_addr,
    input  logic [DW-1:0] lat_data,
    output logic          waking,
    output logic          busy,
    output logic          view_status,
    output logic          do_prog,
    output logic          do_erase,
    output logic          abort_prog,
    output logic          abort_erase,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);
    localparam int CNT_A   = (WAKE_CYC > PROG_CYC) ? WAKE_CYC : PROG_CYC;
    localparam int CNT_MAX = (CNT_A > ERASE_CYC) ? CNT_A : ERASE_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    fbf_state_e    state, state_n;
    fbf_view_e     view, view_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          grab_op;
    logic [7:0]    cmd;

    assign cmd = lat_data[7:0];

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        view_n  = view;
        grab_op = 1'b0;
        unique case (state)
            ST_WAKE: begin
                if (cnt == CW'(1)) state_n = ST_IDLE;
                else               cnt_n   = cnt - CW'(1);
            end
            ST_IDLE: begin
                if (wr_stb) begin
                    case (cmd)
                        CMD_VIEW_ARRAY:  view_n  = RD_ARRAY;
                        CMD_VIEW_STATUS: view_n  = RD_STATUS;
                        CMD_PROG:        state_n = ST_PROG_ARM;
                        CMD_ERASE:       state_n = ST_ERASE_ARM;
                        default:         state_n = ST_IDLE;
                    endcase
                end
            end
            ST_PROG_ARM: begin
                if (wr_stb) begin
                    grab_op = 1'b1;
                    state_n = ST_PROG_RUN;
                    cnt_n   = CW'(PROG_CYC);
                    view_n  = RD_STATUS;
                end
            end
            ST_ERASE_ARM: begin
                if (wr_stb) begin
                    if (cmd == CMD_ERASE_GO) begin
                        grab_op = 1'b1;
                        state_n = ST_ERASE_RUN;
                        cnt_n   = CW'(ERASE_CYC);
                        view_n  = RD_STATUS;
                    end else begin
                        state_n = ST_IDLE;
                        view_n  = RD_ARRAY;
                    end
                end
            end
            ST_PROG_RUN, ST_ERASE_RUN: begin
                if (cnt == CW'(1)) state_n = ST_IDLE;
                else               cnt_n   = cnt - CW'(1);
            end
            default: state_n = ST_WAKE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_s) begin
            state <= ST_WAKE;
            cnt   <= CW'(WAKE_CYC);
            view  <= RD_ARRAY;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            view  <= view_n;
        end
    end

    always_ff @(posedge clk) begin
        if (grab_op) begin
            op_addr <= lat_addr;
            op_data <= lat_data;
        end
    end

    // outputs
    always_comb begin
        waking      = (state == ST_WAKE);
        busy        = (state == ST_PROG_RUN) || (state == ST_ERASE_RUN);
        view_status = (view == RD_STATUS);
        do_prog     = rst_s && (state == ST_PROG_RUN) && (cnt == CW'(1));
        do_erase    = rst_s && (state == ST_ERASE_RUN) && (cnt == CW'(1));
        abort_prog  = !rst_s && (state == ST_PROG_RUN);
        abort_erase = !rst_s && (state == ST_ERASE_RUN);
    end

    p_wake_exit_r2: assert property (@(posedge clk) disable iff (!rst_s)
        (state == ST_WAKE) |=> (state inside {ST_WAKE, ST_IDLE}));

    p_prog_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
        (state == ST_PROG_RUN && cnt != CW'(1)) |=> (state == ST_PROG_RUN));

    p_erase_hold_r8: assert property (@(posedge clk) disable iff (!rst_s)
        (state == ST_ERASE_RUN && cnt != CW'(1)) |=> (state == ST_ERASE_RUN));

    p_prog_done_r7: assert property (@(posedge clk) disable iff (!rst_s)
        do_prog |=> (state == ST_IDLE));

    p_busy_ignores_cmd_r9: assert property (@(posedge clk) disable iff (!rst_s)
        (busy && wr_stb && cnt != CW'(1)) |=> (state == $past(state) && view == $past(view)));
endmodule

// File: rtl/pflash_bus_frontend.sv
module pflash_bus_frontend
    import fbf_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 16,
    parameter int          BLK_W       = 2,
    parameter int          SYNC_STAGES = 2,
    parameter int          WAKE_CYC    = 12,
    parameter int          PROG_CYC    = 16,
    parameter int          ERASE_CYC   = 40,
    parameter logic [15:0] POISON      = 16'hDEAD
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en
);
    localparam int BW = 3 + ADDR_W + DATA_W;

    logic              rst_s;
    logic              cs_s, wr_s, rd_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic [BW-1:0]     bundle_s;

    logic              wr_stb;
    logic [ADDR_W-1:0] lat_addr, op_addr;
    logic [DATA_W-1:0] lat_data, op_data, rd_word;
    logic              waking, busy, view_status;
    logic              do_prog, do_erase, abort_prog, abort_erase;
    logic              en_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] status_word;

    fbf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
        .clk (clk),
        .d   (hw_rst_n),
        .q   (rst_s)
    );

    fbf_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk (clk),
        .d   ({cs_n, wr_n, rd_n, bus_addr, wdata}),
        .q   (bundle_s)
    );

    assign {cs_s, wr_s, rd_s, addr_s, data_s} = bundle_s;

    fbf_wr_capture #(.AW(ADDR_W), .DW(DATA_W)) u_cap (
        .clk      (clk),
        .rst_s    (rst_s),
        .cs_s     (cs_s),
        .wr_s     (wr_s),
        .rd_s     (rd_s),
        .addr_s   (addr_s),
        .data_s   (data_s),
        .wr_stb   (wr_stb),
        .lat_addr (lat_addr),
        .lat_data (lat_data)
    );

    fbf_ctrl #(
        .AW(ADDR_W), .DW(DATA_W), .WAKE_CYC(WAKE_CYC),
        .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_s       (rst_s),
        .wr_stb      (wr_stb),
        .lat_addr    (lat_addr),
        .lat_data    (lat_data),
        .waking      (waking),
        .busy        (busy),
        .view_status (view_status),
        .do_prog     (do_prog),
        .do_erase    (do_erase),
        .abort_prog  (abort_prog),
        .abort_erase (abort_erase),
        .op_addr     (op_addr),
        .op_data     (op_data)
    );

    fbf_store #(.AW(ADDR_W), .DW(DATA_W), .BLK_W(BLK_W), .POISON(POISON)) u_store (
        .clk         (clk),
        .rst_s       (rst_s),
        .do_prog     (do_prog),
        .do_erase    (do_erase),
        .abort_prog  (abort_prog),
        .abort_erase (abort_erase),
        .op_addr     (op_addr),
        .op_data     (op_data),
        .rd_addr     (addr_s),
        .rd_word     (rd_word)
    );

    assign status_word = {{(DATA_W-8){1'b0}}, STAT_READY};

    // read path register
    always_ff @(posedge clk) begin
        if (!rst_s) begin
            en_q  <= 1'b0;
            out_q <= '0;
        end else begin
            en_q <= !cs_s && !rd_s && wr_s && !waking;
            if (busy)             out_q <= '0;
            else if (view_status) out_q <= status_word;
            else                  out_q <= rd_word;
        end
    end

    assign rdata    = out_q;
    assign rdata_en = en_q && hw_rst_n;

    p_busy_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_s)
        busy |=> (rdata == '0));

    p_standby_quiet_r5: assert property (@(posedge clk) disable iff (!rst_s)
        cs_s |=> !rdata_en);

    p_odis_quiet_r4: assert property (@(posedge clk) disable iff (!rst_s)
        rd_s |=> !rdata_en);
endmodule

// File: tb/pflash_bus_frontend_tb_top.sv
`timescale 1ns/1ps
module pflash_bus_frontend_tb_top;
    localparam int AW = 4, DW = 16, BLKW = 2;
    localparam int WAKE = 12, PROG = 16, ERASE = 40;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rdata_en;

    int checks = 0, errors = 0;
    bit cmp_en = 1'b0;

    always #10 clk = ~clk;

    pflash_bus_frontend #(
        .ADDR_W(AW), .DATA_W(DW), .BLK_W(BLKW), .SYNC_STAGES(2),
        .WAKE_CYC(WAKE), .PROG_CYC(PROG), .ERASE_CYC(ERASE), .POISON(16'hDEAD)
    ) dut_i (
        .clk(clk), .hw_rst_n(hw_rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .bus_addr(bus_addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, updated on every rising edge
    bit m_r1, m_r2, m_c1, m_c2, m_w1, m_w2, m_o1, m_o2;
    logic [AW-1:0] m_a1, m_a2, m_la, m_pa;
    logic [DW-1:0] m_d1, m_d2, m_ld, m_pd, m_outq;
    int  m_state = 0, m_cnt = WAKE;  // 0 wake 1 idle 2 prog-arm 3 erase-arm 4 prog-run 5 erase-run
    bit  m_stat, m_actq, m_oeq, m_outk;
    logic [DW-1:0] m_mem [WORDS];
    bit  m_val [WORDS];
    bit  m_kn [WORDS];

    always @(posedge clk) begin : model
        bit busy_m, act_m, stb_m;
        if (!m_r2) begin
            if (m_state == 4) begin m_val[m_pa] = 0; m_kn[m_pa] = 1; end
            if (m_state == 5)
                for (int i = 0; i < WORDS; i++)
                    if ((i >> BLKW) == (int'(m_pa) >> BLKW)) begin m_val[i] = 0; m_kn[i] = 1; end
            m_state = 0; m_cnt = WAKE; m_stat = 0; m_actq = 0; m_oeq = 0; m_outq = '0;
        end else begin
            busy_m = (m_state == 4) || (m_state == 5);
            act_m  = !m_c2 && !m_w2 && m_o2;
            stb_m  = m_actq && (m_c2 || m_w2);
            m_oeq  = !m_c2 && !m_o2 && m_w2 && (m_state != 0);
            if (busy_m) begin m_outq = '0; m_outk = 1; end
            else if (m_stat) begin m_outq = 16'h0080; m_outk = 1; end
            else begin
                m_outq = m_val[m_a2] ? m_mem[m_a2] : 16'hDEAD;
                m_outk = m_kn[m_a2];
            end
            case (m_state)
                0: if (m_cnt == 1) m_state = 1; else m_cnt--;
                1: if (stb_m) begin
                       if (m_ld[7:0] == 8'hFF) m_stat = 0;
                       else if (m_ld[7:0] == 8'h70) m_stat = 1;
                       else if (m_ld[7:0] == 8'h40) m_state = 2;
                       else if (m_ld[7:0] == 8'h20) m_state = 3;
                   end
                2: if (stb_m) begin m_pa = m_la; m_pd = m_ld; m_state = 4; m_cnt = PROG; m_stat = 1; end
                3: if (stb_m) begin
                       if (m_ld[7:0] == 8'hD0) begin m_pa = m_la; m_state = 5; m_cnt = ERASE; m_stat = 1; end
                       else begin m_state = 1; m_stat = 0; end
                   end
                4: if (m_cnt == 1) begin m_mem[m_pa] = m_pd; m_val[m_pa] = 1; m_kn[m_pa] = 1; m_state = 1; end
                   else m_cnt--;
                5: if (m_cnt == 1) begin
                       for (int i = 0; i < WORDS; i++)
                           if ((i >> BLKW) == (int'(m_pa) >> BLKW)) begin m_mem[i] = '1; m_val[i] = 1; m_kn[i] = 1; end
                       m_state = 1;
                   end else m_cnt--;
                default: m_state = 0;
            endcase
            if (act_m) begin m_la = m_a2; m_ld = m_d2; end
            m_actq = act_m;
        end
        m_r2 = m_r1; m_r1 = hw_rst_n;
        m_c2 = m_c1; m_c1 = cs_n;
        m_w2 = m_w1; m_w1 = wr_n;
        m_o2 = m_o1; m_o1 = rd_n;
        m_a2 = m_a1; m_a1 = bus_addr;
        m_d2 = m_d1; m_d1 = wdata;
    end

    // R11: per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(rdata_en == (m_oeq && hw_rst_n), "R11 enable",
                {15'd0, rdata_en}, {15'd0, m_oeq && hw_rst_n});
            if (m_oeq && hw_rst_n && m_outk)
                chk(rdata == m_outq, "R11 data", rdata, m_outq);
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit cs_first);
        tick(); bus_addr = a; wdata = d; cs_n = 0; rd_n = 1;
        tick(); wr_n = 0;
        tick(3);
        if (cs_first) cs_n = 1; else wr_n = 1;
        tick();
        cs_n = 1; wr_n = 1;
        tick(3);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        tick(); bus_addr = a; cs_n = 0; rd_n = 0;
        tick(5);
        @(negedge clk);
        chk(rdata_en == 1'b1, req, {15'd0, rdata_en}, 16'd1);
        chk(rdata == exp, req, rdata, exp);
        tick(); cs_n = 1; rd_n = 1;
        tick(3);
    endtask

    task automatic do_reset(input int n);
        tick(); hw_rst_n = 0;
        repeat (n) begin
            @(negedge clk);
            chk(rdata_en == 1'b0, "R1 reset quiet", {15'd0, rdata_en}, 16'd0);
        end
        tick(); hw_rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        tick(8);
        cmp_en = 1'b1;
        do_reset(4);
        tick(WAKE + 4);

        // R1 / R6: status view after reset
        bus_wr(0, 16'h0070, 0);
        bus_rd(5, 16'h0080, "R1 status after reset");

        // R8 erase block 0, R9 busy behaviour
        bus_wr(0, 16'h0020, 0);
        bus_wr(2, 16'h00D0, 0);
        bus_rd(0, 16'h0000, "R9 busy status");
        bus_wr(0, 16'h00FF, 0);
        bus_rd(1, 16'h0000, "R9 command ignored while busy");
        tick(ERASE + 4);
        bus_rd(1, 16'h0080, "R8 ready after erase");
        bus_wr(0, 16'h00FF, 0);
        bus_rd(0, 16'hFFFF, "R8 erased word 0");
        bus_rd(3, 16'hFFFF, "R8 erased word 3");

        // R7 program, R3 both release orders
        bus_wr(0, 16'h0040, 0);
        bus_wr(1, 16'hA5C3, 0);
        tick(PROG + 4);
        bus_wr(0, 16'h00FF, 1);
        bus_rd(1, 16'hA5C3, "R7 programmed word, wr first");
        bus_wr(0, 16'h0040, 1);
        bus_wr(2, 16'h3C5A, 1);
        tick(PROG + 4);
        bus_wr(0, 16'h00FF, 1);
        bus_rd(2, 16'h3C5A, "R3 programmed word, cs first");

        // R3 write window with rd_n low has no effect
        tick(); bus_addr = 0; wdata = 16'h0070; cs_n = 0; rd_n = 0; wr_n = 0;
        tick(4); wr_n = 1; tick(); cs_n = 1; rd_n = 1; tick(3);
        bus_rd(1, 16'hA5C3, "R3 read-drive low write ignored");

        // R4 output disable, R5 standby
        tick(); bus_addr = 1; cs_n = 0; rd_n = 1; tick(5);
        @(negedge clk); chk(rdata_en == 1'b0, "R4 rd_n high", {15'd0, rdata_en}, 16'd0);
        tick(); cs_n = 1; rd_n = 0; tick(5);
        @(negedge clk); chk(rdata_en == 1'b0, "R5 standby", {15'd0, rdata_en}, 16'd0);
        tick(); rd_n = 1; tick(3);

        // R6 unknown command ignored
        bus_wr(0, 16'h0055, 0);
        bus_rd(1, 16'hA5C3, "R6 unknown code ignored");

        // R8 erase cancel
        bus_wr(0, 16'h0070, 0);
        bus_wr(0, 16'h0020, 0);
        bus_wr(0, 16'h0033, 0);
        bus_rd(1, 16'hA5C3, "R8 erase cancelled to array view");

        // R2 wake window
        bus_wr(0, 16'h0070, 0);
        do_reset(4);
        bus_wr(0, 16'h0070, 0);
        tick(); bus_addr = 1; cs_n = 0; rd_n = 0;
        @(negedge clk); chk(rdata_en == 1'b0, "R2 wake quiet", {15'd0, rdata_en}, 16'd0);
        @(negedge clk); chk(rdata_en == 1'b0, "R2 wake quiet", {15'd0, rdata_en}, 16'd0);
        tick(); cs_n = 1; rd_n = 1;
        tick(WAKE + 4);
        bus_rd(1, 16'hA5C3, "R2 write in wake ignored, R1 array view");

        // R10 abort during program
        bus_wr(0, 16'h0040, 0);
        bus_wr(3, 16'h1111, 0);
        do_reset(4);
        tick(WAKE + 4);
        bus_rd(3, 16'hDEAD, "R10 aborted program word");
        bus_rd(2, 16'h3C5A, "R10 neighbour intact");

        // R10 abort during erase
        bus_wr(0, 16'h0020, 0);
        bus_wr(0, 16'h00D0, 0);
        do_reset(4);
        tick(WAKE + 4);
        bus_rd(1, 16'hDEAD, "R10 aborted erase block");

        tick(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule